// File: doc/BRIEF.md
# DMA Stream Transfer Counter Controller

This block is the control core of a single DMA stream. It holds the count of items still to move, a peripheral-side pointer and a memory-side pointer, and the mode that decides what happens when the count runs out. The external datapath moves one data item at a time. It pulses `item_done` once for each item it completes. On each pulse the controller counts down and advances the pointers by the configured step. At the midpoint and at the end of the count it raises sticky progress flags.

Software programs the stream through a small write-only register port while the stream is idle, then sets the enable bit. A one-shot stream stops when the count reaches zero. A circular stream reloads the count and rewinds both pointers in the same cycle, so the datapath sees no gap. In ping-pong mode the stream also alternates between two memory base addresses, and `cur_target` shows which buffer is being filled. A copy from memory to memory always runs once, whatever the mode bits say. All ports are plain control and status signals: `item_done` is a single-cycle strobe with no back-pressure, and the datapath issues items only while `active` is high.

Top module: `dma_stream_ctl`

## Requirements
- R1: After reset, `active` is 0, `remaining` is 0, `cur_target` is 0, both address outputs are 0, and all three flags are 0.
- R2: A write to select 0 (control) with bit 0 set, made while idle, starts the stream if the programmed count (select 1) is nonzero. On start, `remaining` takes the count, the peripheral pointer takes its base (select 2), the memory pointer takes base 0 (select 3), and `cur_target` becomes 0. A start with a count of 0 is refused.
- R3: Each `item_done` pulse while `active` lowers `remaining` by one. While idle, `item_done` changes neither the count nor the pointers.
- R4: The half flag is set when `remaining` becomes the programmed count divided by two, rounded down.
- R5: The complete flag is set when `remaining` becomes 0. In one-shot mode `active` then drops, and `remaining` stays 0 until the next start.
- R6: In circular mode (control bit 1), reaching zero reloads the programmed count and returns both pointers to their bases in the same cycle, and `active` stays high.
- R7: Ping-pong mode (control bit 2) implies circular reload. Each time the count reaches zero, `cur_target` toggles and the memory pointer moves to the base of the new target: base 1 at select 4 when the target is 1, base 0 when it is 0.
- R8: Direction is set by control bits 4:3: 0 means peripheral to memory, 1 means memory to peripheral, and 2 or 3 means memory to memory. Memory to memory ignores bits 1 and 2 and always stops at zero.
- R9: Control bit 5 enables the peripheral increment and bit 6 enables the memory increment. The step is 1, 2 or 4 for size codes 0, 1 and 2. Code 3 also gives 4. The peripheral size is in bits 8:7 and the memory size in bits 10:9. A disabled increment gives a step of 0.
- R10: `src_addr` shows the memory pointer and `dst_addr` the peripheral pointer for memory to peripheral. For the other directions, `src_addr` shows the peripheral pointer and `dst_addr` the memory pointer.
- R11: A `xfer_err` pulse while active sets the error flag and stops the stream.
- R12: Flags stay set until a write to select 5 clears them, with bit 0 clearing half, bit 1 complete and bit 2 error. A flag set in the same cycle as its clear stays set.
- R13: An `abort` pulse, or a control write with bit 0 clear, stops an active stream at the next edge. An item completed in that same cycle is still counted.
- R14: While active, writes to selects 0 to 4 are ignored, except for the stop described in R13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | DW | Register write data |
| item_done | input | 1 | One data item completed by the datapath |
| xfer_err | input | 1 | Datapath reports a transfer error |
| abort | input | 1 | Stop the stream after the current item |
| active | output | 1 | Stream enabled; the datapath may issue items |
| remaining | output | CW | Items left in the current pass |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| cur_target | output | 1 | Memory buffer in use (0 or 1) |
| flag_half | output | 1 | Sticky half-transfer flag |
| flag_done | output | 1 | Sticky transfer-complete flag |
| flag_err | output | 1 | Sticky transfer-error flag |

## Verification
The bench targets the cycle where the count reaches zero. A controller that reloads late or forgets to rewind would leave a stale address or a zero count in circular mode. One that fails to toggle would refill the same ping-pong buffer. A count of 1 puts the half and complete events on the same item, and memory-to-memory with the circular bits set must still stop. It also covers an abort that coincides with an item, which a careless design would drop; a flag clear that coincides with a new set, which would lose the event; and configuration writes during an active stream, which must not move the reload value.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    DIR_P2M  = 2'd0,
    DIR_M2P  = 2'd1,
    DIR_M2M  = 2'd2,
    DIR_M2MX = 2'd3
  } dir_e;

  // control bits 10:1, MSB first
  typedef struct packed {
    logic [1:0] msize;
    logic [1:0] psize;
    logic       minc;
    logic       pinc;
    dir_e       dir;
    logic       pingpong;
    logic       circ;
  } mode_t;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_COUNT  = 3'd1;
  localparam logic [2:0] SEL_PBASE  = 3'd2;
  localparam logic [2:0] SEL_MBASE0 = 3'd3;
  localparam logic [2:0] SEL_MBASE1 = 3'd4;
  localparam logic [2:0] SEL_FCLR   = 3'd5;

  function automatic logic [2:0] step_of(input logic [1:0] size);
    case (size)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          item,
  input  logic          reload_en,
  input  logic          pingpong_en,
  input  logic [CW-1:0] prog,
  output logic          active,
  output logic [CW-1:0] remaining,
  output logic          target,
  output logic          half_hit,
  output logic          zero_hit,
  output logic          wrap
);

  logic          item_ok;
  logic [CW-1:0] cnt_dec;

  assign item_ok  = item & active;
  assign cnt_dec  = remaining - CW'(1);
  assign half_hit = item_ok && (cnt_dec == (prog >> 1));
  assign zero_hit = item_ok && (remaining == CW'(1));
  assign wrap     = zero_hit & reload_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      remaining <= '0;
      target    <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      remaining <= prog;
      target    <= 1'b0;
    end else begin
      if (item_ok) begin
        remaining <= wrap ? prog : cnt_dec;
        if (wrap && pingpong_en) target <= ~target;
      end
      if (stop || (zero_hit && !reload_en)) active <= 1'b0;
    end
  end

  a_r3_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remaining != '0) && (remaining <= prog));

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (item && active && remaining > CW'(1)) |=> remaining == $past(remaining) - CW'(1));

  a_r5_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (item && active && remaining == CW'(1) && !reload_en) |=> !active);

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (item && active && remaining == CW'(1) && reload_en) |=> remaining == $past(prog));

  a_r7_target_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (item && active && remaining == CW'(1) && reload_en && pingpong_en)
      |=> target != $past(target));

  a_r13_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stop) |=> !active);

endmodule

// File: rtl/dsc_ptr.sv
module dsc_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic          adv,
  input  logic          wrap,
  input  logic [AW-1:0] wrap_base,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_base;
    else if (adv)  ptr <= wrap ? wrap_base : ptr + step;
  end

  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !load) |=> ptr == $past(ptr) + $past(step));

  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !load) |=> ptr == $past(wrap_base));

endmodule

// File: rtl/dsc_flags.sv
module dsc_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(clr[i]));
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
  end

endmodule

// File: rtl/dma_stream_ctl.sv
module dma_stream_ctl
  import dsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          item_done,
  input  logic          xfer_err,
  input  logic          abort,
  output logic          active,
  output logic [CW-1:0] remaining,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          cur_target,
  output logic          flag_half,
  output logic          flag_done,
  output logic          flag_err
);

  localparam int MODE_W = $bits(mode_t);

  mode_t         mode_q;
  logic [CW-1:0] prog_q;
  logic [AW-1:0] pbase_q, mbase0_q, mbase1_q;

  logic wr_ctrl, start, stop, m2m, reload_en, pingpong_en, item_ok;
  logic half_hit, zero_hit, wrap;
  logic [AW-1:0] p_step, m_step, m_wrap_base, pptr, mptr;
  logic [2:0]    fset, fclr, flags;

  assign wr_ctrl     = cfg_wr && (cfg_sel == SEL_CTRL);
  assign start       = wr_ctrl && !active && cfg_wdata[0] && (prog_q != '0);
  assign stop        = active && (abort || xfer_err || (wr_ctrl && !cfg_wdata[0]));
  assign m2m         = mode_q.dir[1];
  assign reload_en   = (mode_q.circ | mode_q.pingpong) & ~m2m;
  assign pingpong_en = mode_q.pingpong & ~m2m;
  assign item_ok     = item_done & active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      prog_q   <= '0;
      pbase_q  <= '0;
      mbase0_q <= '0;
      mbase1_q <= '0;
    end else if (cfg_wr && !active) begin
      case (cfg_sel)
        SEL_CTRL:   mode_q   <= mode_t'(cfg_wdata[MODE_W:1]);
        SEL_COUNT:  prog_q   <= cfg_wdata[CW-1:0];
        SEL_PBASE:  pbase_q  <= cfg_wdata[AW-1:0];
        SEL_MBASE0: mbase0_q <= cfg_wdata[AW-1:0];
        SEL_MBASE1: mbase1_q <= cfg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  dsc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .item(item_done),
    .reload_en(reload_en), .pingpong_en(pingpong_en), .prog(prog_q),
    .active(active), .remaining(remaining), .target(cur_target),
    .half_hit(half_hit), .zero_hit(zero_hit), .wrap(wrap)
  );

  assign p_step      = mode_q.pinc ? AW'(step_of(mode_q.psize)) : '0;
  assign m_step      = mode_q.minc ? AW'(step_of(mode_q.msize)) : '0;
  assign m_wrap_base = (pingpong_en && !cur_target) ? mbase1_q : mbase0_q;

  dsc_ptr #(.AW(AW)) u_pptr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_base(pbase_q),
    .adv(item_ok), .wrap(wrap), .wrap_base(pbase_q), .step(p_step), .ptr(pptr)
  );

  dsc_ptr #(.AW(AW)) u_mptr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_base(mbase0_q),
    .adv(item_ok), .wrap(wrap), .wrap_base(m_wrap_base), .step(m_step), .ptr(mptr)
  );

  assign src_addr = (mode_q.dir == DIR_M2P) ? mptr : pptr;
  assign dst_addr = (mode_q.dir == DIR_M2P) ? pptr : mptr;

  assign fset = {xfer_err & active, zero_hit, half_hit};
  assign fclr = (cfg_wr && cfg_sel == SEL_FCLR) ? cfg_wdata[2:0] : 3'b000;

  dsc_flags #(.NF(3)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .flags(flags)
  );

  assign flag_half = flags[0];
  assign flag_done = flags[1];
  assign flag_err  = flags[2];

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && remaining == $past(prog_q) && !cur_target);

  a_r8_m2m_single: assert property (@(posedge clk) disable iff (!rst_n)
    (active && m2m && item_done && remaining == CW'(1)) |=> !active);

  a_r14_locked: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(prog_q) && $stable(pbase_q) && $stable(mode_q));

  a_r11_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xfer_err) |=> !active && flag_err);

endmodule

// File: tb/dma_stream_ctl_tb.sv
module dma_stream_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        item_done = 1'b0;
  logic        xfer_err = 1'b0;
  logic        abort = 1'b0;
  logic        active, cur_target, flag_half, flag_done, flag_err;
  logic [15:0] remaining;
  logic [31:0] src_addr, dst_addr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dma_stream_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .item_done(item_done), .xfer_err(xfer_err),
    .abort(abort), .active(active), .remaining(remaining),
    .src_addr(src_addr), .dst_addr(dst_addr), .cur_target(cur_target),
    .flag_half(flag_half), .flag_done(flag_done), .flag_err(flag_err)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] cnt;
    logic [7:0]  items;
    logic [15:0] rem;
    logic [31:0] src;
    logic [31:0] dst;
    logic        act;
    logic [2:0]  flg;
    logic        tgt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0241, 16'd8, 8'd3,  16'd5, 32'h1000, 32'h2006, 1'b1, 3'b000, 1'b0}, // R3 R9
    '{16'h0241, 16'd8, 8'd4,  16'd4, 32'h1000, 32'h2008, 1'b1, 3'b001, 1'b0}, // R4
    '{16'h0241, 16'd8, 8'd8,  16'd0, 32'h1000, 32'h2010, 1'b0, 3'b011, 1'b0}, // R5
    '{16'h0243, 16'd8, 8'd8,  16'd8, 32'h1000, 32'h2000, 1'b1, 3'b011, 1'b0}, // R6
    '{16'h0243, 16'd8, 8'd10, 16'd6, 32'h1000, 32'h2004, 1'b1, 3'b011, 1'b0}, // R6
    '{16'h0445, 16'd4, 8'd4,  16'd4, 32'h1000, 32'h3000, 1'b1, 3'b011, 1'b1}, // R7
    '{16'h0445, 16'd4, 8'd9,  16'd3, 32'h1000, 32'h2004, 1'b1, 3'b011, 1'b0}, // R7
    '{16'h0469, 16'd6, 8'd2,  16'd4, 32'h2008, 32'h1002, 1'b1, 3'b000, 1'b0}, // R10
    '{16'h0577, 16'd3, 8'd3,  16'd0, 32'h100C, 32'h200C, 1'b0, 3'b011, 1'b0}, // R8
    '{16'h0241, 16'd1, 8'd1,  16'd0, 32'h1000, 32'h2002, 1'b0, 3'b011, 1'b0}, // R4 R5
    '{16'h01A1, 16'd5, 8'd2,  16'd3, 32'h1008, 32'h2000, 1'b1, 3'b000, 1'b0}  // R9
  };

  task automatic chk(input string req, input string what, input logic [31:0] act_v,
                     input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [31:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic items(input int n);
    for (int i = 0; i < n; i++) begin
      item_done = 1'b1;
      @(negedge clk);
    end
    item_done = 1'b0;
  endtask

  task automatic setup(input logic [15:0] cnt);
    cfg(3'd0, 32'h0);
    cfg(3'd5, 32'h7);
    cfg(3'd1, {16'h0, cnt});
    cfg(3'd2, 32'h1000);
    cfg(3'd3, 32'h2000);
    cfg(3'd4, 32'h3000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "active", {31'b0, active}, 32'h0);
    chk("R1", "remaining", {16'h0, remaining}, 32'h0);
    chk("R1", "flags", {29'b0, flag_err, flag_done, flag_half}, 32'h0);
    chk("R1", "target", {31'b0, cur_target}, 32'h0);
    chk("R1", "src", src_addr, 32'h0);
    chk("R1", "dst", dst_addr, 32'h0);

    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].cnt);
      cfg(3'd0, {16'h0, VECS[v].ctrl});
      items(int'(VECS[v].items));
      chk("R3", "vec remaining", {16'h0, remaining}, {16'h0, VECS[v].rem});
      chk("R10", "vec src", src_addr, VECS[v].src);
      chk("R9", "vec dst", dst_addr, VECS[v].dst);
      chk("R5", "vec active", {31'b0, active}, {31'b0, VECS[v].act});
      chk("R4", "vec flags", {29'b0, flag_err, flag_done, flag_half}, {29'b0, VECS[v].flg});
      chk("R7", "vec target", {31'b0, cur_target}, {31'b0, VECS[v].tgt});
    end

    // R2: count of zero refuses start
    setup(16'd0);
    cfg(3'd0, 32'h241);
    chk("R2", "zero count start", {31'b0, active}, 32'h0);

    // R13: abort together with an item; the item still counts
    setup(16'd8);
    cfg(3'd0, 32'h241);
    chk("R2", "start remaining", {16'h0, remaining}, 32'd8);
    item_done = 1'b1; abort = 1'b1;
    @(negedge clk);
    item_done = 1'b0; abort = 1'b0;
    chk("R13", "abort active", {31'b0, active}, 32'h0);
    chk("R13", "abort remaining", {16'h0, remaining}, 32'd7);
    chk("R13", "abort dst", dst_addr, 32'h2002);

    // R3: items while idle are ignored
    items(2);
    chk("R3", "idle remaining", {16'h0, remaining}, 32'd7);
    chk("R3", "idle dst", dst_addr, 32'h2002);

    // R13: control write with enable clear stops the stream
    cfg(3'd0, 32'h241);
    items(1);
    cfg(3'd0, 32'h240);
    chk("R13", "ctrl stop", {31'b0, active}, 32'h0);
    chk("R2", "restart reload", {16'h0, remaining}, 32'd7);

    // R14: writes during an active stream are ignored
    setup(16'd4);
    cfg(3'd0, 32'h243);
    cfg(3'd1, 32'd2);
    cfg(3'd2, 32'h5000);
    items(4);
    chk("R14", "locked count", {16'h0, remaining}, 32'd4);
    chk("R14", "locked base", src_addr, 32'h1000);
    items(2);
    cfg(3'd5, 32'h7);
    items(1);
    chk("R12", "cleared flags", {29'b0, flag_err, flag_done, flag_half}, 32'h0);

    // R12: complete set in the same cycle as its clear stays set
    item_done = 1'b1; cfg_wr = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h2;
    @(negedge clk);
    item_done = 1'b0; cfg_wr = 1'b0;
    chk("R12", "set wins", {31'b0, flag_done}, 32'h1);
    chk("R6", "circular still active", {31'b0, active}, 32'h1);
    cfg(3'd5, 32'h1);
    chk("R12", "other bit kept", {31'b0, flag_done}, 32'h1);
    cfg(3'd5, 32'h2);
    chk("R12", "w1c clears", {31'b0, flag_done}, 32'h0);

    // R11: transfer error
    xfer_err = 1'b1;
    @(negedge clk);
    xfer_err = 1'b0;
    chk("R11", "error flag", {31'b0, flag_err}, 32'h1);
    chk("R11", "error stops", {31'b0, active}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule